// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This peripheral keeps time from a 32768 Hz slow clock and presents it on a small word-addressed register bus. A free-running counter advances once every N slow-clock ticks, where N is a programmable prescaler. The prescaler resets to 32768, so the counter counts seconds. Two event sources sit beside the counter. The first is an alarm comparator that holds an absolute count. The second is a periodic interval timer that counts raw slow-clock ticks and reloads by itself.

Each event sets a bit in a status register, and reading that register clears it. The interrupt mask is changed only through a set-register and a clear-register, and it can be read back. One level-sensitive interrupt line reports any status bit whose mask bit is set.

The slow clock is sampled by a two-stage synchronizer in the bus clock domain. Its rising edges become single-cycle tick strobes. All state therefore lives in the bus domain, so a counter read can never be torn or out of order.

Top module: `slowclk_sys_timer`

## Requirements
- R1: The counter is CNT_W bits wide (default 20). It steps by exactly one per prescaler period and wraps from 2^CNT_W-1 to 0.
- R2: The prescaler register (word 5, 16 bits) resets to 32768. A value N makes the counter step every N slow ticks, and 0 or 1 makes it step on every tick. Writing it restarts the divider phase.
- R3: Counter reads (word 7) taken while the counter runs never go backwards. Two reads one bus access apart differ by at most one, modulo the wrap.
- R4: The alarm register (word 6) holds an absolute count. Status bit 3 sets on the tick that carries the counter into that value. Writing the count the counter already holds raises no match until a full wrap has passed.
- R5: The status register (word 0) reads as bit 0 period event, bit 1 watchdog (always 0), bit 2 counter step, and bit 3 alarm. A read returns these bits and clears them all.
- R6: Writing a 1 to word 1 sets that mask bit, and writing a 1 to word 2 clears it. Zero bits leave the mask unchanged. Word 3 reads the 4-bit mask back.
- R7: The period register (word 4, 16 bits) sets status bit 0 once every P slow ticks and reloads automatically. Writing it restarts the count, and P = 0 disables the period event.
- R8: An event that arrives in the same cycle as a clearing status read leaves its status bit set.
- R9: The irq output is high exactly when some status bit and its mask bit are both set.
- R10: At reset the counter, status, mask, period and alarm are 0 and irq is low. Register bits beyond each field's width read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk | input | 1 | 32768 Hz slow clock, asynchronous to clk |
| sel | input | 1 | Register access strobe, one cycle per access |
| we | input | 1 | Write when 1, read when 0 |
| word_addr | input | 3 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle sel is high |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at four situations.

- **Counter wrap.** A design that mishandled the carry would stall at all-ones or skip zero.
- **Alarm written with the live count.** A comparator that matched on equality rather than on the step into the value would fire at once instead of one full wrap later.
- **Counter-step event on the same edge as a status read.** A design that let the clear win would lose that event silently.
- **Reads during continuous counting.** A design that returned half-updated or stale counts would show a decrease or a jump of more than one between neighbouring reads.

// File: rtl/slowclk_sys_timer.sv
module slowclk_sys_timer #(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PIT_W   = 16,
  parameter int PRE_RST = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_clk,
  input  logic        sel,
  input  logic        we,
  input  logic [2:0]  word_addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);

  logic [2:0]       sync;
  logic [CNT_W-1:0] cnt, alarm;
  logic [PRE_W-1:0] pre_cnt, presc;
  logic [PIT_W-1:0] period, pit_cnt;
  logic [3:0]       mask, sts;

  wire unused_hi = ^wdata[31:CNT_W];

  wire tick   = sync[1] & ~sync[2];
  wire wr     = sel & we;
  wire rd_sts = sel & ~we & (word_addr == 3'd0);

  wire [PRE_W:0]   pre_inc  = {1'b0, pre_cnt} + 1'b1;
  wire             pre_wrap = tick && (pre_inc >= {1'b0, presc});
  wire [CNT_W-1:0] cnt_nxt  = cnt + 1'b1;
  wire             pit_hit  = tick && (period != '0) && (pit_cnt <= PIT_W'(1));
  wire             alm_hit  = pre_wrap && (cnt_nxt == alarm);
  wire [3:0]       ev       = {alm_hit, pre_wrap, 1'b0, pit_hit};

  assign irq = |(sts & mask);

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], slow_clk};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pre_cnt <= '0; presc <= PRE_W'(PRE_RST);
      period <= '0; pit_cnt <= '0; alarm <= '0;
      mask <= '0; sts <= '0;
    end else begin
      sts <= (rd_sts ? 4'b0 : sts) | ev;
      if (pre_wrap) cnt <= cnt_nxt;

      if (wr && word_addr == 3'd5) begin
        presc   <= wdata[PRE_W-1:0];
        pre_cnt <= '0;
      end else if (tick) begin
        pre_cnt <= pre_wrap ? '0 : pre_inc[PRE_W-1:0];
      end

      if (wr && word_addr == 3'd4) begin
        period  <= wdata[PIT_W-1:0];
        pit_cnt <= wdata[PIT_W-1:0];
      end else if (tick && period != '0) begin
        pit_cnt <= pit_hit ? period : pit_cnt - 1'b1;
      end

      if (wr && word_addr == 3'd6) alarm <= wdata[CNT_W-1:0];
      if (wr && word_addr == 3'd1) mask <= mask | wdata[3:0];
      if (wr && word_addr == 3'd2) mask <= mask & ~wdata[3:0];
    end
  end

  always_comb begin
    case (word_addr)
      3'd0:    rdata = {28'b0, sts};
      3'd3:    rdata = {28'b0, mask};
      3'd4:    rdata = {{(32-PIT_W){1'b0}}, period};
      3'd5:    rdata = {{(32-PRE_W){1'b0}}, presc};
      3'd6:    rdata = {{(32-CNT_W){1'b0}}, alarm};
      3'd7:    rdata = {{(32-CNT_W){1'b0}}, cnt};
      default: rdata = 32'b0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CNT_W'($past(cnt) + 1'b1))); // R1
  AST_ALARM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[3]) |-> (cnt == $past(alarm))); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sts && !pre_wrap && !alm_hit && !pit_hit) |=> (sts == 4'b0)); // R5
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && word_addr == 3'd1) |=> ((mask & $past(wdata[3:0])) == $past(wdata[3:0]))); // R6
  AST_PIT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (pit_hit && !(wr && word_addr == 3'd4)) |=> (pit_cnt == $past(period))); // R7
  AST_ALARM_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    alm_hit |=> sts[3]); // R8
  AST_STEP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    pre_wrap |=> sts[2]); // R8

endmodule

// File: tb/slowclk_sys_timer_bench.sv
`timescale 1ns/1ps
module slowclk_sys_timer_bench;
  localparam int CW = 10;
  localparam int M  = 1 << CW;

  logic clk = 0, rst_n = 0, slow_clk = 0, sel = 0, we = 0;
  logic [2:0]  word_addr = 0;
  logic [31:0] wdata = 0;
  wire  [31:0] rdata;
  wire         irq;

  always #2.5 clk = ~clk;

  slowclk_sys_timer #(.CNT_W(CW)) u_slowclk_sys_timer (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .sel(sel), .we(we),
    .word_addr(word_addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  int n_chk = 0, n_bad = 0, hold = 1;
  int m_cnt = 0, m_pre = 0, m_presc = 32768, m_period = 0, m_pit = 0;
  int m_alarm = 0, m_sts = 0, m_mask = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_tick();
    int ev = 0;
    if (m_period != 0) begin
      if (m_pit <= 1) begin ev |= 1; m_pit = m_period; end
      else m_pit--;
    end
    if (m_pre + 1 >= m_presc) begin
      m_pre = 0;
      m_cnt = (m_cnt + 1) % M;
      ev |= 4;
      if (m_cnt == m_alarm) ev |= 8;
    end else m_pre++;
    m_sts |= ev;
  endtask

  task automatic slow_tick();
    hold++;
    @(negedge clk) slow_clk = 1;
    repeat (4) @(negedge clk);
    slow_clk = 0;
    repeat (4) @(negedge clk);
    model_tick();
    hold--;
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    hold++;
    @(negedge clk);
    sel = 1; we = 1; word_addr = 3'(a); wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
    case (a)
      1: m_mask |= int'(d[3:0]);
      2: m_mask &= ~int'(d[3:0]);
      4: begin m_period = int'(d[15:0]); m_pit = m_period; end
      5: begin m_presc = int'(d[15:0]); m_pre = 0; end
      6: m_alarm = int'(d) & (M - 1);
      default: ;
    endcase
    hold--;
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    hold++;
    @(negedge clk);
    sel = 1; we = 0; word_addr = 3'(a);
    #1 d = rdata;
    @(negedge clk);
    sel = 0;
    if (a == 0) m_sts = 0;
    hold--;
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  always @(negedge clk)
    if (rst_n && hold == 0)
      chk("R9 irq", {31'b0, irq}, {31'b0, (m_sts & m_mask) != 0});

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rd, prev, cur;
    repeat (3) @(negedge clk);
    rst_n = 1;
    hold = 0;

    chk("R10 irq reset", {31'b0, irq}, 0);
    bus_rd(0, rd); chk("R10 status reset", rd, 0);
    bus_rd(3, rd); chk("R10 mask reset", rd, 0);
    bus_rd(5, rd); chk("R2 prescaler reset", rd, 32'h8000);
    bus_rd(4, rd); chk("R10 period reset", rd, 0);
    bus_rd(6, rd); chk("R10 alarm reset", rd, 0);
    bus_rd(7, rd); chk("R10 counter reset", rd, 0);
    bus_wr(4, 32'hFFFF_FFFF);
    bus_rd(4, rd); chk("R10 unused bits", rd, 32'h0000_FFFF);
    bus_wr(4, 0);

    repeat (5) slow_tick();
    bus_rd(7, rd); chk("R2 default divider", rd, 0);
    bus_wr(5, 3);
    repeat (7) slow_tick();
    bus_rd(7, rd); chk("R2 divide by 3", rd, 2);
    bus_wr(5, 1);
    repeat (3) slow_tick();
    bus_rd(7, rd); chk("R1 step per tick", rd, 5);

    bus_rd(0, rd); chk("R5 status bits", rd, 32'h4);
    bus_rd(0, rd); chk("R5 cleared by read", rd, 0);

    bus_wr(1, 9);
    bus_rd(3, rd); chk("R6 set", rd, 9);
    bus_wr(2, 1);
    bus_rd(3, rd); chk("R6 clear", rd, 8);
    bus_wr(1, 0); bus_wr(2, 0);
    bus_rd(3, rd); chk("R6 zero writes", rd, 8);

    bus_wr(1, 4);
    slow_tick();
    chk("R9 irq on step", {31'b0, irq}, 1);
    bus_rd(0, rd);
    chk("R9 irq after read", {31'b0, irq}, 0);
    bus_wr(2, 15);

    bus_wr(6, (m_cnt + 3) % M);
    repeat (2) slow_tick();
    bus_rd(0, rd); chk("R4 alarm not yet", rd & 8, 0);
    slow_tick();
    bus_rd(0, rd); chk("R4 alarm hit", rd & 8, 8);
    bus_rd(7, rd); chk("R4 count at alarm", rd, m_alarm);

    while (m_cnt != M - 1) slow_tick();
    bus_rd(7, rd); chk("R1 top value", rd, M - 1);
    slow_tick();
    bus_rd(7, rd); chk("R1 wrap to zero", rd, 0);

    bus_rd(0, rd);
    bus_wr(6, m_cnt);
    repeat (M - 1) slow_tick();
    bus_rd(0, rd); chk("R4 live count defers", rd & 8, 0);
    slow_tick();
    bus_rd(0, rd); chk("R4 match after wrap", rd & 8, 8);

    bus_wr(6, (m_cnt + 500) % M);
    bus_rd(0, rd);
    bus_wr(4, 3);
    repeat (2) slow_tick();
    bus_rd(0, rd); chk("R7 period early", rd & 1, 0);
    slow_tick();
    bus_rd(0, rd); chk("R7 period event", rd & 1, 1);
    repeat (3) slow_tick();
    bus_rd(0, rd); chk("R7 reload", rd & 1, 1);
    chk("R5 full status", rd, 32'h5);
    bus_wr(4, 0);

    hold++;
    @(negedge clk) slow_clk = 1;
    @(negedge clk);
    @(negedge clk);
    sel = 1; we = 0; word_addr = 3'd0;
    #1 rd = rdata;
    @(negedge clk);
    sel = 0;
    repeat (2) @(negedge clk);
    slow_clk = 0;
    repeat (4) @(negedge clk);
    m_sts = 0;
    model_tick();
    hold--;
    chk("R5 read before clash", rd, 0);
    bus_rd(0, rd); chk("R8 event kept", rd & 4, 4);

    bus_rd(7, prev);
    fork
      begin
        repeat (100) slow_tick();
        done = 1;
      end
      begin
        while (!done) begin
          bus_rd(7, cur);
          chk("R3 monotonic", {31'b0, ((cur - prev) & (M - 1)) <= 1}, 1);
          prev = cur;
        end
      end
    join
    bus_rd(7, rd); chk("R3 final count", rd, m_cnt);

    summary();
    $finish;
  end
endmodule